// File: doc/BRIEF.md
# Framebuffer Fetch Sequencer

This block is the memory-read front end of a raster display controller. It walks a window of memory from a start address up to an inclusive end address. It reads the window in bursts over a simple request/grant read port and pushes each returned word into an internal pixel FIFO. The raster side drains the FIFO. While the raster enable stays set, the window is fetched again and again, one pass per frame.

Before normal scanout, software can select a palette pass instead. In that pass the block reads a fixed 32-byte table once, keeps it out of the pixel FIFO, reports completion and waits. The start/end pair is written as one 64-bit word and is sampled only when a frame begins. When the raster is disabled, the frame in flight finishes first, and only then is a stop reported. Four write-one-to-clear status flags are gated by an interrupt-enable mask, which software sets and clears through separate registers, onto one registered interrupt line.

Top module: `lcd_fetch_seq`

## Requirements
- R1: After reset, status_o, irq_o, mem_req_o, pix_valid_o and pix_ready_o are all 0.
- R2: A data frame reads whole words from the start address to the end address inclusive, in ascending order, and delivers them to the pixel FIFO in that order. Frames repeat while CTRL bit 0 (raster enable) is set.
- R3: CTRL bits [4:2] hold a burst code k in 0..4, which means bursts of 2^k words. The last burst of a frame is cut to the words that remain. A request is raised only when the FIFO has room for the whole burst, and it is held stable until granted.
- R4: Burst codes 5, 6 and 7 are rejected. The block raises no memory request until a valid code is written.
- R5: With CTRL bit 1 set, a frame start reads 32 bytes from the start address exactly once. None of it enters the pixel FIFO. Status bit 1 is set, and no further fetch or stop flag follows until the raster enable is cleared.
- R6: Register 0 takes the start address in data bits [31:0] and the end address in bits [63:32] in one write. A new pair written mid-frame is used only from the next frame start.
- R7: Status bit 0 is set when the last word of each data frame is received.
- R8: When the raster enable is cleared mid-frame, the current frame still completes. Status bit 2 is then set, and no further memory request follows.
- R9: pix_ready_o rises once the FIFO holds at least CTRL[12:8] words during a data frame. It stays high until the fetch engine goes idle.
- R10: A pop while the FIFO is empty and pix_ready_o is high sets status bit 3. The bit stays set until it is cleared.
- R11: Writing ones to register 2 clears the matching status bits. Bits written as zero keep their value, and a new event in the same cycle wins over the clear.
- R12: Register 3 sets and register 4 clears bits of the interrupt mask. irq_o is the registered OR of status AND mask, so it follows a change one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index (0 window, 1 control, 2 status, 3 mask set, 4 mask clear) |
| reg_wdata_i | input | 64 | Register write data |
| status_o | output | 4 | Status flags {underflow, stopped, palette done, end of frame} |
| irq_o | output | 1 | Interrupt request |
| mem_req_o | output | 1 | Burst read request |
| mem_addr_o | output | AW | Burst byte address |
| mem_len_o | output | 5 | Burst length in words |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read beat valid |
| mem_rdata_i | input | DW | Read beat data |
| pix_pop_i | input | 1 | Raster side pops one word |
| pix_data_o | output | DW | FIFO head word |
| pix_valid_o | output | 1 | FIFO not empty |
| pix_ready_o | output | 1 | Fill threshold reached, raster may consume |

## Verification
The bench sweeps every valid burst code over a window whose length is not a multiple of most bursts. A design that failed to cut the last burst would read past the end address, and the per-grant length check would catch it. It clears the enable right after an end-of-frame event. A design that stopped at once would deliver one frame of words instead of two and would miss the second end-of-frame. It rewrites the window in the middle of a frame. A design that sampled the pair live would switch addresses mid-frame, and the address check on every popped word would catch it. It also runs the palette pass, which must keep its words out of the FIFO and must not loop. It checks that the rejected burst codes stay silent, and it checks the one-cycle lag of the interrupt line together with the sticky underflow and write-one-to-clear behaviour.

// File: rtl/lcd_fetch_pkg.sv
package lcd_fetch_pkg;
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA, S_HOLD} fetch_state_e;

  localparam logic [2:0] REG_WINDOW = 3'd0;
  localparam logic [2:0] REG_CTRL   = 3'd1;
  localparam logic [2:0] REG_STATUS = 3'd2;
  localparam logic [2:0] REG_IE_SET = 3'd3;
  localparam logic [2:0] REG_IE_CLR = 3'd4;

  localparam int NSTAT   = 4;
  localparam int BIT_EOF = 0;
  localparam int BIT_PAL = 1;
  localparam int BIT_DONE = 2;
  localparam int BIT_UFL = 3;

  localparam int PAL_BYTES  = 32;
  localparam int MAX_BCODE  = 4;
  localparam int THR_LSB    = 8;
endpackage

// File: rtl/lcd_fetch_fifo.sv
module lcd_fetch_fifo #(
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic [CW-1:0] count_o
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_pop, do_push;

  assign valid_o = (cnt_q != '0);
  assign do_pop  = pop_i && valid_o;
  assign do_push = push_i;
  assign data_o  = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  // engine must never push into a full FIFO
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CW'(DEPTH)));

  assert_count_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/lcd_fetch_regs.sv
module lcd_fetch_regs
  import lcd_fetch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [63:0]      reg_wdata_i,
  input  logic [NSTAT-1:0] set_i,
  output logic [AW-1:0]    base_o,
  output logic [AW-1:0]    ceil_o,
  output logic             en_o,
  output logic             pal_mode_o,
  output logic [2:0]       bcode_o,
  output logic [CW-1:0]    thr_o,
  output logic [NSTAT-1:0] status_o,
  output logic             irq_o
);
  logic [AW-1:0]    base_q, ceil_q;
  logic             en_q, pal_q;
  logic [2:0]       bcode_q;
  logic [CW-1:0]    thr_q;
  logic [NSTAT-1:0] stat_q, ie_q, stat_clr, ie_set, ie_clr;
  logic             irq_q;

  always_comb begin
    stat_clr = '0;
    ie_set   = '0;
    ie_clr   = '0;
    if (reg_we_i) begin
      if (reg_addr_i == REG_STATUS) stat_clr = reg_wdata_i[NSTAT-1:0];
      if (reg_addr_i == REG_IE_SET) ie_set   = reg_wdata_i[NSTAT-1:0];
      if (reg_addr_i == REG_IE_CLR) ie_clr   = reg_wdata_i[NSTAT-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      ceil_q  <= '0;
      en_q    <= 1'b0;
      pal_q   <= 1'b0;
      bcode_q <= '0;
      thr_q   <= '0;
      stat_q  <= '0;
      ie_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == REG_WINDOW) begin
        base_q <= reg_wdata_i[AW-1:0];
        ceil_q <= reg_wdata_i[32 +: AW];
      end
      if (reg_we_i && reg_addr_i == REG_CTRL) begin
        en_q    <= reg_wdata_i[0];
        pal_q   <= reg_wdata_i[1];
        bcode_q <= reg_wdata_i[4:2];
        thr_q   <= reg_wdata_i[THR_LSB +: CW];
      end
      stat_q <= (stat_q & ~stat_clr) | set_i;
      ie_q   <= (ie_q | ie_set) & ~ie_clr;
      irq_q  <= |(stat_q & ie_q);
    end
  end

  assign base_o     = base_q;
  assign ceil_o     = ceil_q;
  assign en_o       = en_q;
  assign pal_mode_o = pal_q;
  assign bcode_o    = bcode_q;
  assign thr_o      = thr_q;
  assign status_o   = stat_q;
  assign irq_o      = irq_q;

  assert_w1c_eof_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_STATUS && reg_wdata_i[BIT_EOF] && !set_i[BIT_EOF])
      |=> !status_o[BIT_EOF]);

  assert_sticky_ufl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[BIT_UFL] && !(reg_we_i && reg_addr_i == REG_STATUS && reg_wdata_i[BIT_UFL]))
      |=> status_o[BIT_UFL]);

  assert_irq_masked_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == '0 && !(reg_we_i && reg_addr_i == REG_IE_SET)) |=> !irq_o);
endmodule

// File: rtl/lcd_fetch_engine.sv
module lcd_fetch_engine
  import lcd_fetch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          pal_mode_i,
  input  logic [2:0]    bcode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ceil_i,
  input  logic [CW-1:0] fifo_free_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [4:0]    mem_len_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          push_o,
  output logic [DW-1:0] push_data_o,
  output logic          eof_o,
  output logic          pal_done_o,
  output logic          frame_done_o,
  output logic          active_o
);
  localparam int BYTES     = DW / 8;
  localparam int SH        = $clog2(BYTES);
  localparam int LW        = AW - SH + 1;
  localparam int PAL_WORDS = PAL_BYTES / BYTES;

  fetch_state_e  state_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] left_q, frame_words_c;
  logic          pal_q;
  logic [4:0]    bwords_q, len_q, beat_q, len_c;
  logic          start_ok, space_ok, beat, last_word;

  assign start_ok = en_i && (bcode_i <= 3'(MAX_BCODE));

  always_comb begin
    if (pal_mode_i) frame_words_c = LW'(PAL_WORDS);
    else            frame_words_c = LW'((ceil_i - base_i) >> SH) + LW'(1);
  end

  always_comb begin
    if (left_q < LW'(bwords_q)) len_c = left_q[4:0];
    else                        len_c = bwords_q;
  end

  assign space_ok  = pal_q || (32'(fifo_free_i) >= 32'(len_c));
  assign beat      = (state_q == S_DATA) && mem_rvalid_i;
  assign last_word = beat && (left_q == LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      left_q   <= '0;
      pal_q    <= 1'b0;
      bwords_q <= 5'd1;
      len_q    <= '0;
      beat_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start_ok) begin
            addr_q   <= base_i;
            left_q   <= frame_words_c;
            pal_q    <= pal_mode_i;
            bwords_q <= 5'd1 << bcode_i;
            state_q  <= S_REQ;
          end
        end
        S_REQ: begin
          if (mem_req_o && mem_gnt_i) begin
            len_q   <= len_c;
            beat_q  <= '0;
            state_q <= S_DATA;
          end
        end
        S_DATA: begin
          if (mem_rvalid_i) begin
            addr_q <= addr_q + AW'(BYTES);
            left_q <= left_q - LW'(1);
            beat_q <= beat_q + 5'd1;
            if (left_q == LW'(1)) begin
              if (pal_q) begin
                state_q <= S_HOLD;
              end else if (start_ok) begin
                // frame boundary: the window pair is sampled here only
                addr_q   <= base_i;
                left_q   <= frame_words_c;
                pal_q    <= pal_mode_i;
                bwords_q <= 5'd1 << bcode_i;
                state_q  <= S_REQ;
              end else begin
                state_q <= S_IDLE;
              end
            end else if (beat_q == len_q - 5'd1) begin
              state_q <= S_REQ;
            end
          end
        end
        S_HOLD: begin
          if (!en_i) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o    = (state_q == S_REQ) && space_ok;
  assign mem_addr_o   = addr_q;
  assign mem_len_o    = len_c;
  assign push_o       = beat && !pal_q;
  assign push_data_o  = mem_rdata_i;
  assign eof_o        = last_word && !pal_q;
  assign pal_done_o   = last_word && pal_q;
  assign frame_done_o = last_word && !pal_q && !en_i;
  assign active_o     = ((state_q == S_REQ) || (state_q == S_DATA)) && !pal_q;

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_len_o)));

  assert_burst_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_len_o != 5'd0 && mem_len_o <= bwords_q));

  assert_quiet_after_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !mem_req_o);

  assert_invalid_code_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && bcode_i > 3'(MAX_BCODE)) |=> !mem_req_o);
endmodule

// File: rtl/lcd_fetch_seq.sv
module lcd_fetch_seq
  import lcd_fetch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [63:0]      reg_wdata_i,
  output logic [NSTAT-1:0] status_o,
  output logic             irq_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [4:0]       mem_len_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             pix_pop_i,
  output logic [DW-1:0]    pix_data_o,
  output logic             pix_valid_o,
  output logic             pix_ready_o
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [AW-1:0]    base, ceil;
  logic             en, pal_mode, push, eof, pal_done, frame_done, eng_active;
  logic [2:0]       bcode;
  logic [CW-1:0]    thr, fifo_cnt, fifo_free;
  logic [DW-1:0]    push_data;
  logic [NSTAT-1:0] stat_set;
  logic             cons_q, ufl;

  assign fifo_free = CW'(DEPTH) - fifo_cnt;
  assign ufl       = pix_pop_i && !pix_valid_o && cons_q;

  always_comb begin
    stat_set           = '0;
    stat_set[BIT_EOF]  = eof;
    stat_set[BIT_PAL]  = pal_done;
    stat_set[BIT_DONE] = frame_done;
    stat_set[BIT_UFL]  = ufl;
  end

  lcd_fetch_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .set_i(stat_set), .base_o(base), .ceil_o(ceil), .en_o(en),
    .pal_mode_o(pal_mode), .bcode_o(bcode), .thr_o(thr),
    .status_o, .irq_o
  );

  lcd_fetch_engine #(.AW(AW), .DW(DW), .CW(CW)) u_engine (
    .clk_i, .rst_ni, .en_i(en), .pal_mode_i(pal_mode), .bcode_i(bcode),
    .base_i(base), .ceil_i(ceil), .fifo_free_i(fifo_free),
    .mem_req_o, .mem_addr_o, .mem_len_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .push_o(push), .push_data_o(push_data), .eof_o(eof), .pal_done_o(pal_done),
    .frame_done_o(frame_done), .active_o(eng_active)
  );

  lcd_fetch_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .data_i(push_data), .pop_i(pix_pop_i),
    .data_o(pix_data_o), .valid_o(pix_valid_o), .count_o(fifo_cnt)
  );

  // consumption window: opens at threshold, closes when the engine idles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cons_q <= 1'b0;
    else if (!eng_active)        cons_q <= 1'b0;
    else if (fifo_cnt >= thr)    cons_q <= 1'b1;
  end

  assign pix_ready_o = cons_q;

  assert_underflow_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_pop_i && !pix_valid_o && pix_ready_o) |=> status_o[BIT_UFL]);
endmodule

// File: tb/lcd_fetch_seq_tb.sv
module lcd_fetch_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [63:0] reg_wdata_i = '0;
  logic [3:0]  status_o;
  logic        irq_o, mem_req_o, mem_gnt_i, mem_rvalid_i;
  logic [31:0] mem_addr_o, mem_rdata_i, pix_data_o;
  logic [4:0]  mem_len_o;
  logic        pix_pop_i, pix_valid_o, pix_ready_o;

  always #2.5 clk = ~clk;

  lcd_fetch_seq u_dut (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .status_o, .irq_o, .mem_req_o, .mem_addr_o, .mem_len_o, .mem_gnt_i,
    .mem_rvalid_i, .mem_rdata_i, .pix_pop_i, .pix_data_o, .pix_valid_o, .pix_ready_o
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int req_cnt, beat_cnt, pop_cnt, bl_err, data_err;
  int frame_words, bw, idx;
  logic [31:0] exp_base, next_base, last_beat_addr, first_grant;
  bit cons_en, chk_en, man_pop, saw_b;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model: grant, then one beat per cycle with data = byte address
  initial begin
    int pend, m_left, el;
    logic [31:0] maddr;
    pend = 0; m_left = 0; maddr = '0;
    mem_gnt_i = 0; mem_rvalid_i = 0; mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      mem_gnt_i = 0; mem_rvalid_i = 0;
      if (!rst_ni) begin
        pend = 0; m_left = 0;
      end else if (pend > 0) begin
        mem_rvalid_i = 1; mem_rdata_i = maddr; last_beat_addr = maddr;
        maddr += 4; pend--; beat_cnt++;
      end else if (mem_req_o) begin
        mem_gnt_i = 1; maddr = mem_addr_o; pend = int'(mem_len_o); req_cnt++;
        if (req_cnt == 1) first_grant = mem_addr_o;
        if (mem_addr_o == 32'h8000) saw_b = 1;
        if (m_left == 0) m_left = frame_words;
        el = (bw < m_left) ? bw : m_left;
        if (int'(mem_len_o) != el) bl_err++;
        m_left -= int'(mem_len_o);
      end
    end
  end

  // raster-side consumer with address check
  initial begin
    pix_pop_i = 0;
    forever begin
      @(negedge clk);
      pix_pop_i = 0;
      if (man_pop) pix_pop_i = 1;
      else if (cons_en && pix_valid_o) begin
        pix_pop_i = 1;
        if (chk_en && pix_data_o != exp_base + 32'(4 * idx)) data_err++;
        idx++; pop_cnt++;
        if (idx == frame_words) begin idx = 0; exp_base = next_base; end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 0;
  endtask

  function automatic logic [63:0] ctrl(input bit en, input bit pal,
                                      input int code, input int thr);
    return 64'(en) | (64'(pal) << 1) | (64'(code) << 2) | (64'(thr) << 8);
  endfunction

  function automatic logic [63:0] win(input logic [31:0] b, input int words);
    return {b + 32'(4 * words) - 32'd1, b};
  endfunction

  task automatic do_reset(input logic [31:0] b, input int words, input int burst);
    @(negedge clk);
    rst_ni = 0; cons_en = 0; chk_en = 1; man_pop = 0;
    repeat (3) @(negedge clk);
    req_cnt = 0; beat_cnt = 0; pop_cnt = 0; bl_err = 0; data_err = 0; idx = 0;
    saw_b = 0; first_grant = '0; last_beat_addr = '0;
    exp_base = b; next_base = b; frame_words = words; bw = burst;
    rst_ni = 1;
  endtask

  task automatic wait_stat(input int b, input int lim, input string req);
    int n = 0;
    while (!status_o[b] && n < lim) begin @(negedge clk); n++; end
    chk(status_o[b] == 1'b1, req, "status bit awaited", status_o[b], 1);
  endtask

  initial begin
    int rc;
    do_reset(32'h0, 4, 1);
    @(negedge clk);
    // R1
    chk(status_o == 0, "R1", "status after reset", status_o, 0);
    chk(irq_o == 0, "R1", "irq after reset", irq_o, 0);
    chk(mem_req_o == 0 && pix_valid_o == 0 && pix_ready_o == 0, "R1", "idle outputs",
        {mem_req_o, pix_valid_o, pix_ready_o}, 0);

    // R2 R3 R7 R8: every valid burst code, 11-word window, stop after first frame
    for (int code = 0; code <= 4; code++) begin
      do_reset(32'h1000, 11, 1 << code);
      cons_en = 1;
      wr(3'd0, win(32'h1000, 11));
      wr(3'd1, ctrl(1, 0, code, 0));
      wait_stat(0, 2000, "R7");
      wr(3'd1, ctrl(0, 0, code, 0));
      wr(3'd2, 64'h1);
      wait_stat(2, 2000, "R8");
      repeat (20) @(negedge clk);
      chk(pop_cnt == 22, "R8", "words after stop (current frame finished)", pop_cnt, 22);
      chk(beat_cnt == 22, "R2", "words read", beat_cnt, 22);
      chk(data_err == 0, "R2", "address order errors", data_err, 0);
      chk(bl_err == 0, "R3", "burst length errors", bl_err, 0);
      chk(status_o[0] == 1, "R7", "eof of second frame", status_o[0], 1);
      rc = req_cnt;
      repeat (50) @(negedge clk);
      chk(req_cnt == rc, "R8", "requests after stop", req_cnt, rc);
    end

    // R4: rejected burst codes
    for (int code = 5; code <= 7; code++) begin
      do_reset(32'h1000, 11, 4);
      cons_en = 1;
      wr(3'd0, win(32'h1000, 11));
      wr(3'd1, ctrl(1, 0, code, 0));
      repeat (60) @(negedge clk);
      chk(req_cnt == 0, "R4", "requests with invalid code", req_cnt, 0);
      chk(status_o == 0, "R4", "status with invalid code", status_o, 0);
      wr(3'd1, ctrl(1, 0, 2, 0));
      repeat (30) @(negedge clk);
      chk(req_cnt > 0, "R4", "fetch after valid code", req_cnt, 1);
    end

    // R5: palette pass, then data
    do_reset(32'h2000, 8, 2);
    cons_en = 1;
    wr(3'd0, win(32'h2000, 8));
    wr(3'd1, ctrl(1, 1, 1, 0));
    wait_stat(1, 500, "R5");
    repeat (40) @(negedge clk);
    chk(beat_cnt == 8, "R5", "palette words read", beat_cnt, 8);
    chk(req_cnt == 4, "R5", "palette bursts", req_cnt, 4);
    chk(first_grant == 32'h2000 && last_beat_addr == 32'h201C, "R5", "palette last address",
        last_beat_addr, 32'h201C);
    chk(pop_cnt == 0, "R5", "palette words in FIFO", pop_cnt, 0);
    chk(status_o == 4'b0010, "R5", "only palette flag", status_o, 2);
    wr(3'd1, ctrl(0, 1, 1, 0));
    repeat (20) @(negedge clk);
    chk(status_o[2] == 0, "R5", "no stop flag after palette", status_o[2], 0);
    wr(3'd1, ctrl(1, 0, 1, 0));
    wait_stat(0, 500, "R7");
    chk(pop_cnt >= 8 && data_err == 0, "R5", "data after palette", data_err, 0);

    // R6: window pair change mid-frame
    do_reset(32'h4000, 11, 4);
    cons_en = 1;
    wr(3'd0, win(32'h4000, 11));
    wr(3'd1, ctrl(1, 0, 2, 0));
    while (beat_cnt < 3) @(negedge clk);
    wr(3'd0, win(32'h8000, 11));
    next_base = 32'h8000;
    rc = 0;
    while (pop_cnt < 27 && rc < 2000) begin @(negedge clk); rc++; end
    wr(3'd1, ctrl(0, 0, 2, 0));
    wait_stat(2, 2000, "R8");
    chk(data_err == 0, "R6", "addresses across window change", data_err, 0);
    chk(saw_b == 1, "R6", "new window used", saw_b, 1);
    chk(bl_err == 0, "R3", "burst lengths", bl_err, 0);

    // R11 R12: mask and clear
    do_reset(32'h0, 4, 4);
    cons_en = 1;
    wr(3'd0, win(32'h0, 4));
    wr(3'd1, ctrl(1, 0, 2, 0));
    wait_stat(0, 500, "R7");
    wr(3'd1, ctrl(0, 0, 2, 0));
    wait_stat(2, 500, "R8");
    @(negedge clk);
    chk(irq_o == 0, "R12", "irq masked", irq_o, 0);
    wr(3'd3, 64'h4);
    chk(irq_o == 0, "R12", "irq one cycle late", irq_o, 0);
    @(negedge clk);
    chk(irq_o == 1, "R12", "irq after mask set", irq_o, 1);
    wr(3'd2, 64'h1);
    chk(status_o == 4'b0100, "R11", "clear eof keeps stop flag", status_o, 4);
    @(negedge clk);
    chk(irq_o == 1, "R12", "irq stays for unmasked stop", irq_o, 1);
    wr(3'd4, 64'h4);
    @(negedge clk);
    chk(irq_o == 0, "R12", "irq after mask clear", irq_o, 0);
    wr(3'd2, 64'h4);
    chk(status_o == 0, "R11", "status after clear", status_o, 0);

    // R9 R10: threshold and underflow
    do_reset(32'h0, 64, 1);
    wr(3'd0, win(32'h0, 64));
    wr(3'd3, 64'h8);
    wr(3'd1, ctrl(1, 0, 0, 6));
    while (beat_cnt < 3) @(negedge clk);
    @(negedge clk);
    chk(pix_ready_o == 0, "R9", "ready below threshold", pix_ready_o, 0);
    rc = 0;
    while (!pix_ready_o && rc < 500) begin @(negedge clk); rc++; end
    chk(pix_ready_o == 1 && beat_cnt >= 6, "R9", "words at ready", beat_cnt, 6);
    chk(status_o[3] == 0, "R10", "no underflow before drain", status_o[3], 0);
    man_pop = 1;
    repeat (30) @(negedge clk);
    man_pop = 0;
    @(negedge clk);
    chk(status_o[3] == 1, "R10", "underflow flag", status_o[3], 1);
    @(negedge clk);
    chk(irq_o == 1, "R12", "irq on underflow", irq_o, 1);
    wr(3'd1, ctrl(1, 0, 0, 31));
    repeat (10) @(negedge clk);
    chk(status_o[3] == 1, "R10", "underflow sticky", status_o[3], 1);
    wr(3'd2, 64'h8);
    @(negedge clk);
    chk(status_o[3] == 0, "R11", "underflow cleared", status_o[3], 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule